// File: doc/BRIEF.md
# I2C Event Flag and Clock-Stretch Controller

This block holds the event status flags of an I2C controller and the ordered register accesses that software uses to acknowledge them. The protocol engine sends single-cycle pulses when a start condition has gone out, when an address has been matched or sent, when a 10-bit header has been sent, and when a byte has been received. The CPU side provides one-cycle read strobes for status register 1, status register 2 and the data register, plus a write strobe for the data register.

Three of the flags need a two-step acknowledgement. The first step is always a status-1 read, and it arms the flags that are set at that moment. The second step is a data-register write for the start and header flags, or a status-2 read for the address flag. Any other access drops the armed state. While a start, address or header event is still unserviced, the block asks the pin logic to hold SCL low. An event interrupt follows the flags when it is enabled.

In a single-byte receive, software uses the window between the address flag setting and its clearing to program NACK and STOP. Because SCL is held low for that whole window, the byte cannot finish before software is ready.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: After reset, every flag, `evt_irq` and `scl_hold` are 0.
- R2: `ev_start_sent` sets `flg_start`. The flag clears only when a `rd_sr1` strobe is followed by a `wr_dr` strobe, with no other access between them. Idle cycles between the two steps are allowed.
- R3: `ev_addr` sets `flg_addr`. The flag clears only when a `rd_sr1` strobe is followed by a `rd_sr2` strobe.
- R4: `ev_hdr10_sent` sets `flg_hdr10`. The flag clears only when a `rd_sr1` strobe is followed by a `wr_dr` strobe.
- R5: `ev_byte_rx` sets `flg_rxne`. A single `rd_dr` strobe clears it, and no status read is needed before it.
- R6: A second-step access with no status-1 read before it has no effect. If any other access (for example `rd_dr`) comes between the status-1 read and the second step, the sequence is cancelled and the flag stays set.
- R7: If a flag's set pulse arrives in the same cycle as the access that would clear it, the flag stays set.
- R8: `evt_irq` is 1 exactly when `evt_irq_en` is 1 and at least one of the four flags is set.
- R9: `scl_hold` goes to 1 one cycle after any of `flg_start`, `flg_addr` or `flg_hdr10` becomes 1. It goes to 0 one cycle after the last of them clears. `flg_rxne` on its own never raises `scl_hold`.
- R10: A status-1 read arms only the flags that are set when the read happens. A flag that sets after that read is not cleared by the second step that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_sent | input | 1 | Pulse: start condition sent |
| ev_addr | input | 1 | Pulse: address matched or sent |
| ev_hdr10_sent | input | 1 | Pulse: 10-bit header sent |
| ev_byte_rx | input | 1 | Pulse: byte received into the data register |
| rd_sr1 | input | 1 | Status register 1 read strobe |
| rd_sr2 | input | 1 | Status register 2 read strobe |
| rd_dr | input | 1 | Data register read strobe |
| wr_dr | input | 1 | Data register write strobe |
| evt_irq_en | input | 1 | Event interrupt enable |
| flg_start | output | 1 | Start-sent flag |
| flg_addr | output | 1 | Address flag |
| flg_hdr10 | output | 1 | 10-bit header-sent flag |
| flg_rxne | output | 1 | Receive buffer not empty flag |
| evt_irq | output | 1 | Event interrupt |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
A flag changes at the first clock edge after its set pulse or its clearing strobe. `evt_irq` is combinational from the flags, so it is valid in that same cycle. `scl_hold` is registered from the flags and lags them by one further edge. The bench drives each stimulus for one cycle starting at a falling edge and checks flags and the interrupt at the next falling edge. It checks `scl_hold` at both that falling edge and the one after, so that both the old value and the new value are confirmed.

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start_sent,
  input  logic ev_addr,
  input  logic ev_hdr10_sent,
  input  logic ev_byte_rx,
  input  logic rd_sr1,
  input  logic rd_sr2,
  input  logic rd_dr,
  input  logic wr_dr,
  input  logic evt_irq_en,
  output logic flg_start,
  output logic flg_addr,
  output logic flg_hdr10,
  output logic flg_rxne,
  output logic evt_irq,
  output logic scl_hold
);

  logic arm_start, arm_addr, arm_hdr10;

  wire any_acc   = rd_sr1 | rd_sr2 | rd_dr | wr_dr;
  wire clr_start = wr_dr & arm_start;
  wire clr_hdr10 = wr_dr & arm_hdr10;
  wire clr_addr  = rd_sr2 & arm_addr;
  wire stretch   = flg_start | flg_addr | flg_hdr10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_start <= 1'b0;
      flg_addr  <= 1'b0;
      flg_hdr10 <= 1'b0;
      flg_rxne  <= 1'b0;
    end else begin
      flg_start <= ev_start_sent | (flg_start & ~clr_start);
      flg_addr  <= ev_addr       | (flg_addr  & ~clr_addr);
      flg_hdr10 <= ev_hdr10_sent | (flg_hdr10 & ~clr_hdr10);
      flg_rxne  <= ev_byte_rx    | (flg_rxne  & ~rd_dr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_start <= 1'b0;
      arm_addr  <= 1'b0;
      arm_hdr10 <= 1'b0;
    end else if (rd_sr1) begin
      arm_start <= flg_start;
      arm_addr  <= flg_addr;
      arm_hdr10 <= flg_hdr10;
    end else if (any_acc) begin
      arm_start <= 1'b0;
      arm_addr  <= 1'b0;
      arm_hdr10 <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) scl_hold <= 1'b0;
    else        scl_hold <= stretch;
  end

  assign evt_irq = evt_irq_en & (stretch | flg_rxne);

endmodule

// File: rtl/i2c_evt_ctrl_chk.sv
module i2c_evt_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_start_sent,
  input logic ev_addr,
  input logic ev_hdr10_sent,
  input logic ev_byte_rx,
  input logic rd_sr2,
  input logic rd_dr,
  input logic wr_dr,
  input logic evt_irq_en,
  input logic flg_start,
  input logic flg_addr,
  input logic flg_hdr10,
  input logic flg_rxne,
  input logic evt_irq,
  input logic scl_hold
);

  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flg_start && !wr_dr |=> flg_start);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_addr && !rd_sr2 |=> flg_addr);

  p_hdr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flg_hdr10 && !wr_dr |=> flg_hdr10);

  p_rxne_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flg_rxne && !rd_dr |=> flg_rxne);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_sent || ev_addr |=> flg_start || flg_addr);

  p_hdr_rx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr10_sent && ev_byte_rx |=> flg_hdr10 && flg_rxne);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_irq_en |-> !evt_irq);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flg_start || flg_addr || flg_hdr10 || flg_rxne) |-> !evt_irq);

  p_hold_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_addr) |=> scl_hold);

  p_hold_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_hold) |-> !$past(flg_start || flg_addr || flg_hdr10));

endmodule

bind i2c_evt_ctrl i2c_evt_ctrl_chk chk_i (.*);

// File: tb/i2c_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_evt_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start_sent = 0, ev_addr = 0, ev_hdr10_sent = 0, ev_byte_rx = 0;
  logic rd_sr1 = 0, rd_sr2 = 0, rd_dr = 0, wr_dr = 0, evt_irq_en = 0;
  logic flg_start, flg_addr, flg_hdr10, flg_rxne, evt_irq, scl_hold;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [7:0] E_SB = 8'h80, E_AD = 8'h40, E_HD = 8'h20, E_RX = 8'h10;
  localparam logic [7:0] A_S1 = 8'h08, A_S2 = 8'h04, A_RD = 8'h02, A_WR = 8'h01;

  always #10 clk = ~clk;

  i2c_evt_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic act, input logic exp);
    chk(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic step(input logic [7:0] v);
    {ev_start_sent, ev_addr, ev_hdr10_sent, ev_byte_rx, rd_sr1, rd_sr2, rd_dr, wr_dr} = v;
    @(negedge clk);
    {ev_start_sent, ev_addr, ev_hdr10_sent, ev_byte_rx, rd_sr1, rd_sr2, rd_dr, wr_dr} = 8'h00;
  endtask

  task automatic t_reset;
    chkv("R1 flg_start", flg_start, 0);
    chkv("R1 flg_addr", flg_addr, 0);
    chkv("R1 flg_hdr10", flg_hdr10, 0);
    chkv("R1 flg_rxne", flg_rxne, 0);
    chkv("R1 evt_irq", evt_irq, 0);
    chkv("R1 scl_hold", scl_hold, 0);
  endtask

  task automatic t_start;
    evt_irq_en = 1;
    step(E_SB);
    chkv("R2 start set", flg_start, 1);
    chkv("R8 irq on", evt_irq, 1);
    chkv("R9 hold lags set", scl_hold, 0);
    step(0);
    chkv("R9 hold up", scl_hold, 1);
    step(A_S1);
    chkv("R2 still set after sr1", flg_start, 1);
    step(0);
    step(A_WR);
    chkv("R2 start cleared", flg_start, 0);
    chkv("R9 hold lags clear", scl_hold, 1);
    chkv("R8 irq off", evt_irq, 0);
    step(0);
    chkv("R9 hold released", scl_hold, 0);
  endtask

  task automatic t_addr;
    step(E_AD);
    step(A_S1);
    chkv("R3 addr held after sr1", flg_addr, 1);
    step(A_S2);
    chkv("R3 addr cleared", flg_addr, 0);
    step(0);
    chkv("R3 hold released", scl_hold, 0);
  endtask

  task automatic t_hdr;
    step(E_HD);
    step(0);
    chkv("R4 hold for header", scl_hold, 1);
    step(A_S1);
    step(A_WR);
    chkv("R4 header cleared", flg_hdr10, 0);
  endtask

  task automatic t_rxne;
    step(E_RX);
    chkv("R5 rxne set", flg_rxne, 1);
    step(0);
    chkv("R9 rxne no stretch", scl_hold, 0);
    step(A_RD);
    chkv("R5 rxne cleared", flg_rxne, 0);
  endtask

  task automatic t_order;
    step(E_SB);
    step(A_WR);
    chkv("R6 bare write ignored", flg_start, 1);
    step(A_S1);
    step(A_RD);
    step(A_WR);
    chkv("R6 interrupted seq ignored", flg_start, 1);
    step(E_AD);
    step(A_S1);
    step(A_WR);
    step(A_S2);
    chkv("R6 wrong second step", flg_addr, 1);
    step(A_S1);
    step(A_WR);
    step(A_S1);
    step(A_S2);
    chkv("R6 cleanup start", flg_start, 0);
    chkv("R6 cleanup addr", flg_addr, 0);
  endtask

  task automatic t_setwin;
    step(E_SB);
    step(A_S1);
    step(E_SB | A_WR);
    chkv("R7 start set wins", flg_start, 1);
    step(E_RX);
    step(E_RX | A_RD);
    chkv("R7 rxne set wins", flg_rxne, 1);
    step(A_S1);
    step(A_WR);
    step(A_RD);
    chkv("R7 cleanup", flg_start | flg_rxne, 0);
  endtask

  task automatic t_irq;
    evt_irq_en = 0;
    step(E_RX);
    chkv("R8 irq masked", evt_irq, 0);
    evt_irq_en = 1;
    #1;
    chkv("R8 irq enabled", evt_irq, 1);
    step(A_RD);
    chkv("R8 irq no flags", evt_irq, 0);
  endtask

  task automatic t_snap;
    step(A_S1);
    step(E_AD);
    step(A_S2);
    chkv("R10 late flag not cleared", flg_addr, 1);
    step(A_S1);
    step(A_S2);
    chkv("R10 rearmed clear", flg_addr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_start;
    t_addr;
    t_hdr;
    t_rxne;
    t_order;
    t_setwin;
    t_irq;
    t_snap;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule